// File: doc/BRIEF.md
# Flag-Conditioned Register Move Execute Unit

This unit is the execute step of a conditional register move in a 64-bit general-purpose register machine. Each operation arrives with a decoded 4-bit condition selector and five status flags: carry, zero, sign, overflow and parity. It also carries an operand width code, a 64-bit-mode indication, a bus-lock prefix indication, the destination register field with its extension bit, the current destination contents and the source operand. The unit evaluates the condition and merges the source into the old destination according to the operand width. It flags encodings that are not legal as an undefined-opcode fault.

The result, the register write enable, the destination index and the fault come out registered, one clock after the input valid pulse. A false condition does not always suppress the write. A 32-bit operation in 64-bit mode still rewrites the register, because the upper half is cleared while the low half is kept.

Top module: `cmov_exec_unit`

## Requirements
- R1: Selector values 0 to 7 take the move when, respectively: OF=1; OF=0; CF=1; CF=0; ZF=1; ZF=0; CF=1 or ZF=1; CF=0 and ZF=0.
- R2: Selector values 8 to 15 take the move when, respectively: SF=1; SF=0; PF=1; PF=0; SF differs from OF; SF equals OF; ZF=1 or SF differs from OF; ZF=0 and SF equals OF.
- R3: The width code on `size_code` is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Code 0 is illegal and raises `out_fault`.
- R4: Width code 3 is legal only while `long_mode` is 1. Outside 64-bit mode it raises `out_fault`.
- R5: When the condition holds on a legal operation, `out_we` is 1. The result is the whole source at 64 bits. At 32 bits it is the low 32 source bits with bits 63:32 zero. At 16 bits it is the low 16 source bits with bits 63:16 taken from the old destination.
- R6: When the condition fails at 32 bits in 64-bit mode, `out_we` is 1 and the result has bits 63:32 zero and bits 31:0 taken from the old destination.
- R7: When the condition fails in any other legal case (16 bits, 64 bits, or 32 bits outside 64-bit mode), `out_we` is 0 and the result equals the old destination.
- R8: With `lock_pfx` set, `out_fault` is 1, `out_we` is 0 and the result equals the old destination, whatever the condition.
- R9: `out_idx` is `{reg_ext, reg_field}` in 64-bit mode. Outside it, the extension bit is ignored and `out_idx[3]` is 0.
- R10: All outputs appear on the clock edge after an `in_valid` cycle. `out_valid` is 0 after any cycle without `in_valid`, and a synchronous `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| cond_sel | input | 4 | Condition selector |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| size_code | input | 2 | Operand width code |
| long_mode | input | 1 | 64-bit mode active |
| lock_pfx | input | 1 | Bus-lock prefix present |
| reg_field | input | 3 | Destination register field |
| reg_ext | input | 1 | Register-extension prefix bit |
| dst_val | input | 64 | Current destination contents |
| src_val | input | 64 | Source operand |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | New destination value |
| out_we | output | 1 | Register write enable |
| out_idx | output | 4 | Destination register index |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions assume that `dst_val`, `size_code`, `lock_pfx` and the other operand inputs are meaningful only in a cycle where `in_valid` is high. They compare the registered result with the values sampled in that cycle. They also assume that `rst` is high or low for whole cycles. The stimulus changes every operand input together with `in_valid` at the falling edge. It covers all sixteen selectors against all 32 flag combinations, all four width codes both inside and outside 64-bit mode, and one pulse issued while reset is held.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } op_size_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;
endpackage

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  flags_t           flags,
  output logic             take
);
  localparam int BASE_N = 1 << (SEL_W - 1);

  logic [BASE_N-1:0] base;
  logic              sgn_ne;

  assign sgn_ne = flags.sf ^ flags.of;

  // Even selectors test a base predicate, odd selectors test its inverse.
  always_comb begin
    base    = '0;
    base[0] = flags.of;
    base[1] = flags.cf;
    base[2] = flags.zf;
    base[3] = flags.cf | flags.zf;
    base[4] = flags.sf;
    base[5] = flags.pf;
    base[6] = sgn_ne;
    base[7] = flags.zf | sgn_ne;
  end

  assign take = base[sel[SEL_W-1:1]] ^ sel[0];
endmodule

// File: rtl/cmov_fault_check.sv
module cmov_fault_check
  import cmov_pkg::*;
(
  input  op_size_e size,
  input  logic     long_mode,
  input  logic     lock_pfx,
  output logic     fault
);
  logic bad_size;

  always_comb begin
    unique case (size)
      SZ_8:    bad_size = 1'b1;
      SZ_64:   bad_size = !long_mode;
      default: bad_size = 1'b0;
    endcase
  end

  assign fault = lock_pfx | bad_size;
endmodule

// File: rtl/cmov_size_merge.sv
module cmov_size_merge
  import cmov_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_size_e        size,
  input  logic            long_mode,
  input  logic            take,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] result,
  output logic            we
);
  localparam int HALF = XLEN / 2;
  localparam int QTR  = XLEN / 4;

  logic [XLEN-1:0] tmp;

  // Source is always captured, independent of the condition outcome.
  assign tmp = src_val;

  always_comb begin
    result = old_val;
    we     = 1'b0;
    if (take) begin
      we = 1'b1;
      unique case (size)
        SZ_16:   result = {old_val[XLEN-1:QTR], tmp[QTR-1:0]};
        SZ_32:   result = {{HALF{1'b0}}, tmp[HALF-1:0]};
        default: result = tmp;
      endcase
    end else if (size == SZ_32 && long_mode) begin
      we     = 1'b1;
      result = {{HALF{1'b0}}, old_val[HALF-1:0]};
    end
  end
endmodule

// File: rtl/cmov_exec_unit.sv
module cmov_exec_unit
  import cmov_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int SEL_W  = 4,
  parameter int REG_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             flag_cf,
  input  logic             flag_zf,
  input  logic             flag_sf,
  input  logic             flag_of,
  input  logic             flag_pf,
  input  logic [1:0]       size_code,
  input  logic             long_mode,
  input  logic             lock_pfx,
  input  logic [REG_W-1:0] reg_field,
  input  logic             reg_ext,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data,
  output logic             out_we,
  output logic [REG_W:0]   out_idx,
  output logic             out_fault
);
  localparam int HALF = XLEN / 2;
  localparam int QTR  = XLEN / 4;

  flags_t          flags;
  op_size_e        size;
  logic            take;
  logic            fault;
  logic [XLEN-1:0] merged;
  logic            merged_we;

  assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};
  assign size  = op_size_e'(size_code);

  cmov_cond_eval #(.SEL_W(SEL_W)) u_cond (
    .sel   (cond_sel),
    .flags (flags),
    .take  (take)
  );

  cmov_fault_check u_fault (
    .size      (size),
    .long_mode (long_mode),
    .lock_pfx  (lock_pfx),
    .fault     (fault)
  );

  cmov_size_merge #(.XLEN(XLEN)) u_merge (
    .size      (size),
    .long_mode (long_mode),
    .take      (take),
    .old_val   (dst_val),
    .src_val   (src_val),
    .result    (merged),
    .we        (merged_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
      out_idx   <= '0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= fault;
        out_we    <= merged_we & ~fault;
        out_data  <= fault ? dst_val : merged;
        out_idx   <= {reg_ext & long_mode, reg_field};
      end
    end
  end

  // R10: one-cycle valid latency
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: a faulting operation never writes and returns the old value
  assert_fault_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lock_pfx) |=> (out_fault && !out_we && out_data == $past(dst_val)));
  // R7: without a write the old value is returned
  assert_nowrite_keeps_old_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_we || out_data == $past(dst_val)));
  // R5: 16-bit operations keep the upper bits of the destination
  assert_narrow_keeps_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd1) |=>
      out_data[XLEN-1:QTR] == $past(dst_val[XLEN-1:QTR]));
  // R6: 32-bit operations in 64-bit mode always write with the upper half clear
  assert_w32_clears_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd2 && long_mode && !lock_pfx) |=>
      (out_we && out_data[XLEN-1:HALF] == '0));
  // R4: wide width outside 64-bit mode faults
  assert_wide_needs_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd3 && !long_mode) |=> out_fault);
  // R9: extension bit ignored outside 64-bit mode
  assert_idx_ext_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !long_mode) |=> !out_idx[REG_W]);
endmodule

// File: tb/cmov_exec_unit_tb.sv
module cmov_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_of = 0, flag_pf = 0;
  logic [1:0]  size_code = 2'd2;
  logic        long_mode = 1'b1;
  logic        lock_pfx = 1'b0;
  logic [2:0]  reg_field = '0;
  logic        reg_ext = 1'b0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_we;
  logic [3:0]  out_idx;
  logic        out_fault;

  int checks = 0;
  int errors = 0;
  logic [69:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  cmov_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .flag_pf(flag_pf), .size_code(size_code), .long_mode(long_mode),
    .lock_pfx(lock_pfx), .reg_field(reg_field), .reg_ext(reg_ext),
    .dst_val(dst_val), .src_val(src_val), .out_valid(out_valid),
    .out_data(out_data), .out_we(out_we), .out_idx(out_idx), .out_fault(out_fault)
  );

  // fl = {cf, zf, sf, of, pf}
  function automatic logic cond_ok(input logic [3:0] c, input logic [4:0] fl);
    logic cf, zf, sf, of, pf;
    {cf, zf, sf, of, pf} = fl;
    case (c)
      4'd0:  return of;
      4'd1:  return !of;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return zf;
      4'd5:  return !zf;
      4'd6:  return cf || zf;
      4'd7:  return !cf && !zf;
      4'd8:  return sf;
      4'd9:  return !sf;
      4'd10: return pf;
      4'd11: return !pf;
      4'd12: return sf != of;
      4'd13: return sf == of;
      4'd14: return zf || (sf != of);
      default: return !zf && (sf == of);
    endcase
  endfunction

  // returns {fault, we, idx[3:0], data[63:0]}
  function automatic logic [69:0] model(input logic [3:0] c, input logic [4:0] fl,
      input logic [1:0] sz, input logic lm, input logic lk, input logic [2:0] rf,
      input logic re, input logic [63:0] old, input logic [63:0] src);
    logic        f, w, t;
    logic [63:0] d;
    f = lk || sz == 2'd0 || (sz == 2'd3 && !lm);
    t = cond_ok(c, fl);
    w = 1'b0;
    d = old;
    if (!f) begin
      if (t) begin
        w = 1'b1;
        if (sz == 2'd1)      d = {old[63:16], src[15:0]};
        else if (sz == 2'd2) d = {32'h0, src[31:0]};
        else                 d = src;
      end else if (sz == 2'd2 && lm) begin
        w = 1'b1;
        d = {32'h0, old[31:0]};
      end
    end
    return {f, w, (re && lm), rf, d};
  endfunction

  task automatic send(input logic [3:0] c, input logic [4:0] fl, input logic [1:0] sz,
      input logic lm, input logic lk, input logic [2:0] rf, input logic re,
      input logic [63:0] old, input logic [63:0] src, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    cond_sel  = c;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = fl;
    size_code = sz;
    long_mode = lm;
    lock_pfx  = lk;
    reg_field = rf;
    reg_ext   = re;
    dst_val   = old;
    src_val   = src;
    exp_q.push_back(model(c, fl, sz, lm, lk, rf, re, old, src));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
        end else begin
          logic [69:0] e;
          string       tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if ({out_fault, out_we, out_idx, out_data} !== e) begin
            errors++;
            $display("FAIL %s: actual f=%b we=%b idx=%h d=%h expected f=%b we=%b idx=%h d=%h",
              tg, out_fault, out_we, out_idx, out_data, e[69], e[68], e[67:64], e[63:0]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] old_a, src_a;
    old_a = 64'hDEAD_BEEF_CAFE_F00D;
    src_a = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset out_valid actual %b expected 0", out_valid);
    end
    rst = 1'b0;

    // R1 / R2: every selector against every flag combination, 64-bit width
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        send(4'(c), 5'(f), 2'd3, 1'b1, 1'b0, 3'(c % 8), 1'b0,
             old_a ^ 64'(f), src_a + 64'(c * 32 + f), (c < 8) ? "R1" : "R2");
    idle(2);

    // R5: true condition at each legal width (selector 4, ZF=1)
    send(4'd4, 5'b01000, 2'd3, 1'b1, 1'b0, 3'd1, 1'b0, old_a, src_a, "R5");
    send(4'd4, 5'b01000, 2'd2, 1'b1, 1'b0, 3'd2, 1'b0, old_a, src_a, "R5");
    send(4'd4, 5'b01000, 2'd1, 1'b1, 1'b0, 3'd3, 1'b0, old_a, src_a, "R5");
    send(4'd4, 5'b01000, 2'd2, 1'b0, 1'b0, 3'd3, 1'b0, old_a, src_a, "R5");
    // R6: false condition, 32-bit in 64-bit mode
    send(4'd4, 5'b00000, 2'd2, 1'b1, 1'b0, 3'd4, 1'b0, old_a, src_a, "R6");
    send(4'd15, 5'b01000, 2'd2, 1'b1, 1'b0, 3'd4, 1'b1, old_a, src_a, "R6");
    // R7: false condition elsewhere
    send(4'd4, 5'b00000, 2'd1, 1'b1, 1'b0, 3'd5, 1'b0, old_a, src_a, "R7");
    send(4'd4, 5'b00000, 2'd3, 1'b1, 1'b0, 3'd5, 1'b0, old_a, src_a, "R7");
    send(4'd4, 5'b00000, 2'd2, 1'b0, 1'b0, 3'd5, 1'b0, old_a, src_a, "R7");
    send(4'd4, 5'b00000, 2'd1, 1'b0, 1'b0, 3'd5, 1'b0, old_a, src_a, "R7");
    // R3: 8-bit width is illegal
    send(4'd4, 5'b01000, 2'd0, 1'b1, 1'b0, 3'd6, 1'b0, old_a, src_a, "R3");
    send(4'd5, 5'b01000, 2'd0, 1'b0, 1'b0, 3'd6, 1'b0, old_a, src_a, "R3");
    // R4: 64-bit width outside 64-bit mode
    send(4'd4, 5'b01000, 2'd3, 1'b0, 1'b0, 3'd7, 1'b0, old_a, src_a, "R4");
    send(4'd5, 5'b01000, 2'd3, 1'b0, 1'b0, 3'd7, 1'b0, old_a, src_a, "R4");
    // R8: lock prefix, condition true and false, several widths
    send(4'd4, 5'b01000, 2'd3, 1'b1, 1'b1, 3'd0, 1'b0, old_a, src_a, "R8");
    send(4'd4, 5'b00000, 2'd2, 1'b1, 1'b1, 3'd0, 1'b0, old_a, src_a, "R8");
    send(4'd4, 5'b01000, 2'd1, 1'b0, 1'b1, 3'd0, 1'b0, old_a, src_a, "R8");
    idle(1);
    // R9: register extension
    send(4'd4, 5'b01000, 2'd2, 1'b1, 1'b0, 3'd7, 1'b1, old_a, src_a, "R9");
    send(4'd4, 5'b01000, 2'd2, 1'b0, 1'b0, 3'd7, 1'b1, old_a, src_a, "R9");
    send(4'd4, 5'b01000, 2'd1, 1'b1, 1'b0, 3'd0, 1'b1, old_a, src_a, "R9");
    idle(3);

    // R10: a pulse under reset yields no output
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: pulse during reset actual out_valid %b expected 0", out_valid);
    end
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: missing results actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule